// File: doc/BRIEF.md
# Data-Strobe Serial Link Transmitter

This block turns a stream of link tokens into characters on a two-wire data/strobe line. A token is either a byte or a two-bit control code, marked by a type flag. The block adds an odd parity bit and the type flag to each token. Whenever it has nothing to send, it fills the line with NULL, which is the escape code followed by the flow-control code. A request input makes the block send stand-alone flow-control characters. Data characters go out only while the credit input is non-zero. Each data character sent produces one pulse on a consumed-credit output.

The wire pair uses the usual data/strobe scheme. The data wire carries each bit as it is. The strobe wire changes only when the data value repeats. The receiver can therefore rebuild the bit clock from the exclusive-or of the two wires. A built-in divider sets the line rate to one bit every `DIV_N` system clocks. Lowering the enable silences the line and clears the parity history.

Top module: `ds_link_tx`

## Requirements
- R1: A data character is sent as a parity bit, then a type flag of 0, then the 8 data bits with bit 0 first.
- R2: A control character is sent as a parity bit, then a type flag of 1, then the code field c, with c[1] first and c[0] second. The code values are: flow control 00, normal end of packet 01, exceptional end of packet 10, escape 11. A control token takes its code from tok_data[1:0].
- R3: Take the code or data bits of the preceding character, the current parity bit and the current flag together. The number of ones in this set is odd.
- R4: With no token to send and no flow-control request pending, the line carries NULL (escape, then flow control) without a gap.
- R5: At each bit boundary exactly one of ds_d and ds_s changes, and ds_d equals the bit being sent.
- R6: While enabled, a new bit starts every DIV_N system clock cycles.
- R7: A data token is accepted only while credit is non-zero. Control tokens are accepted whatever the credit value.
- R8: credit_use is high for exactly one cycle for each data token accepted, and never for a control token.
- R9: Each flow-control request produces one stand-alone flow-control character. It is sent before any data token not yet started, and it never splits a character already on the line.
- R10: While link_en is low, or during reset, ds_d and ds_s are 0 and no token is accepted. After enable, the first character's parity covers only its own parity bit and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_en | input | 1 | Runs the line when high; holds it quiet when low |
| credit | input | CREDIT_W | Outstanding receiver credit; non-zero allows data characters |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token taken at this clock edge |
| tok_ctrl | input | 1 | 1 = control token, 0 = data token |
| tok_data | input | 8 | Byte, or control code in bits [1:0] |
| fcc_req | input | 1 | Asks for one stand-alone flow-control character |
| credit_use | output | 1 | One-cycle pulse per data token accepted |
| ds_d | output | 1 | Data wire |
| ds_s | output | 1 | Strobe wire |

## Verification
A flow-control request and a waiting data token can both be ready at the same character boundary. In that case the scheduler must pick the flow-control character and hold the token back. The bench provokes this by pulsing the request while bytes are offered back to back with credit available. It decodes the wire pair and counts the data characters that complete between each request and the stand-alone flow-control character. At most one may complete, and it must be the character already on the line.

// File: rtl/ds_tx_pkg.sv
// Package for the data/strobe transmitter.
// Holds the control code values, the character record and the functions that
// build each character. Bit 0 of a character vector goes on the line first.
package ds_tx_pkg;

    localparam int CHAR_MAX = 10;
    localparam int LEN_W    = 4;

    typedef logic [1:0] ctrl_code_t;

    localparam ctrl_code_t CODE_FCC = 2'b00;
    localparam ctrl_code_t CODE_EOP = 2'b01;
    localparam ctrl_code_t CODE_EEP = 2'b10;
    localparam ctrl_code_t CODE_ESC = 2'b11;

    typedef struct packed {
        logic [CHAR_MAX-1:0] bits;     // bit 0 is sent first
        logic [LEN_W-1:0]    len;      // number of bits in the character
        logic                pay_par;  // xor of the payload, used by the next character
    } char_t;

    // Data character: parity, flag 0, then byte bit 0 first.
    function automatic char_t mk_data(input logic prev_par, input logic [7:0] b);
        char_t c;
        c.bits    = {b, 1'b0, ~prev_par};
        c.len     = LEN_W'(10);
        c.pay_par = ^b;
        return c;
    endfunction

    // Control character: parity, flag 1, then code[1] and code[0].
    function automatic char_t mk_ctrl(input logic prev_par, input ctrl_code_t code);
        char_t c;
        c.bits    = {6'b000000, code[0], code[1], 1'b1, prev_par};
        c.len     = LEN_W'(4);
        c.pay_par = ^code;
        return c;
    endfunction

    // NULL filler: escape, then flow control, sent as one 8-bit unit.
    // The parity of the flow-control half follows from the escape payload (11).
    function automatic char_t mk_null(input logic prev_par);
        char_t c;
        c.bits    = {2'b00, 4'b0010, 3'b111, prev_par};
        c.len     = LEN_W'(8);
        c.pay_par = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/ds_tx_baud.sv
// Bit-rate divider.
// Produces a one-cycle bit_tick every DIV_N clocks while link_en is high.
// Assumes DIV_N >= 1. The count restarts from zero whenever link_en is low.
module ds_tx_baud #(
    parameter int DIV_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    output logic bit_tick
);
    localparam int CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

    logic [CNT_W-1:0] cnt;

    // Tick when the count reaches its last value.
    assign bit_tick = link_en && (cnt == LAST);

    // Divider count, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (DIV_N > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                bit_tick |=> !bit_tick) else $error("tick spacing"); // R6
        end
    endgenerate

endmodule

// File: rtl/ds_tx_sched.sv
// Character scheduler.
// At each load slot it picks one character: a pending flow-control request
// first, then an offered token (data only with credit), otherwise NULL.
// It also keeps the payload parity of the last character loaded.
// Assumes load is high only at a bit tick with the shifter empty.
module ds_tx_sched
    import ds_tx_pkg::*;
#(
    parameter int CREDIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_en,
    input  logic                load,
    input  logic [CREDIT_W-1:0] credit,
    input  logic                tok_valid,
    input  logic                tok_ctrl,
    input  logic [7:0]          tok_data,
    input  logic                fcc_req,
    output logic                tok_ready,
    output logic                credit_use,
    output char_t               next_char
);
    logic fcc_pend;
    logic prev_par;
    logic take_tok;

    // A token may go if no request is waiting and data has credit.
    assign take_tok   = !fcc_pend && tok_valid && (tok_ctrl || (|credit));
    assign tok_ready  = load && take_tok;
    assign credit_use = tok_ready && !tok_ctrl;

    // Pick the character for the next load slot.
    always_comb begin
        if (fcc_pend) begin
            next_char = mk_ctrl(prev_par, CODE_FCC);
        end else if (take_tok && tok_ctrl) begin
            next_char = mk_ctrl(prev_par, tok_data[1:0]);
        end else if (take_tok) begin
            next_char = mk_data(prev_par, tok_data);
        end else begin
            next_char = mk_null(prev_par);
        end
    end

    // Flow-control request latch; a new request wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcc_pend <= 1'b0;
        end else if (fcc_req) begin
            fcc_pend <= 1'b1;
        end else if (load) begin
            fcc_pend <= 1'b0;
        end
    end

    // Parity history, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            prev_par <= 1'b0;
        end else if (load) begin
            prev_par <= next_char.pay_par;
        end
    end

    AST_DATA_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_ready && !tok_ctrl) |-> (credit != '0)) else $error("data without credit"); // R7
    AST_FCC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fcc_pend && load) |-> !tok_ready) else $error("token passed pending fcc"); // R9
    AST_CREDIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        credit_use |=> !credit_use) else $error("credit pulse too long"); // R8

endmodule

// File: rtl/ds_tx_shift.sv
// Character shifter.
// Sends one bit per tick, least index first. When the current character is
// finished it loads the scheduler's character on the same tick, so there is
// no idle bit between characters. Cleared while disabled.
module ds_tx_shift
    import ds_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_en,
    input  logic                bit_tick,
    input  logic [CHAR_MAX-1:0] load_bits,
    input  logic [LEN_W-1:0]    load_len,
    output logic                empty,
    output logic                load,
    output logic                line_bit
);
    logic [CHAR_MAX-1:0] sr;
    logic [LEN_W-1:0]    rem;

    assign empty    = (rem == '0);
    assign load     = bit_tick && empty;
    assign line_bit = empty ? load_bits[0] : sr[0];

    // Shift out the character, or take a new one when the last bit has gone.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            sr  <= '0;
            rem <= '0;
        end else if (bit_tick) begin
            if (empty) begin
                sr  <= load_bits >> 1;
                rem <= load_len - 1'b1;
            end else begin
                sr  <= sr >> 1;
                rem <= rem - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ds_tx_line_enc.sv
// Data/strobe line encoder.
// On each tick, D takes the new bit. S flips when D does not change, so
// exactly one wire moves per bit. Both wires are 0 while disabled.
module ds_tx_line_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic bit_tick,
    input  logic line_bit,
    output logic ds_d,
    output logic ds_s
);
    // Register the two wires.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            ds_d <= 1'b0;
            ds_s <= 1'b0;
        end else if (bit_tick) begin
            ds_d <= line_bit;
            ds_s <= (line_bit == ds_d) ? ~ds_s : ds_s;
        end
    end

    AST_ONE_WIRE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && link_en) |=> ((ds_d != $past(ds_d)) != (ds_s != $past(ds_s))))
        else $error("both or neither wire moved"); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!ds_d && !ds_s)) else $error("line active while disabled"); // R10

endmodule

// File: rtl/ds_link_tx.sv
// Data/strobe link transmitter top.
// Connects the bit divider, character scheduler, shifter and line encoder.
// Assumes tokens are held stable while tok_valid is high and not yet taken.
module ds_link_tx
    import ds_tx_pkg::*;
#(
    parameter int DIV_N    = 2,
    parameter int CREDIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_en,
    input  logic [CREDIT_W-1:0] credit,
    input  logic                tok_valid,
    output logic                tok_ready,
    input  logic                tok_ctrl,
    input  logic [7:0]          tok_data,
    input  logic                fcc_req,
    output logic                credit_use,
    output logic                ds_d,
    output logic                ds_s
);
    logic  bit_tick;
    logic  load;
    logic  empty;
    logic  line_bit;
    char_t next_char;

    ds_tx_baud #(.DIV_N(DIV_N)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .bit_tick (bit_tick)
    );

    ds_tx_sched #(.CREDIT_W(CREDIT_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_en    (link_en),
        .load       (load),
        .credit     (credit),
        .tok_valid  (tok_valid),
        .tok_ctrl   (tok_ctrl),
        .tok_data   (tok_data),
        .fcc_req    (fcc_req),
        .tok_ready  (tok_ready),
        .credit_use (credit_use),
        .next_char  (next_char)
    );

    ds_tx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .bit_tick  (bit_tick),
        .load_bits (next_char.bits),
        .load_len  (next_char.len),
        .empty     (empty),
        .load      (load),
        .line_bit  (line_bit)
    );

    ds_tx_line_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .bit_tick (bit_tick),
        .line_bit (line_bit),
        .ds_d     (ds_d),
        .ds_s     (ds_s)
    );

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        tok_ready |-> empty) else $error("token taken mid-character"); // R9
    AST_NO_TAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> !tok_ready) else $error("token taken while disabled"); // R10

endmodule

// File: tb/ds_link_tx_tb_top.sv
// Bench: drives tokens and requests, decodes the wire pair back into
// characters and compares them with values worked out from the requirements.
module ds_link_tx_tb_top;
    localparam int NDIV = 2;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_en = 1'b0;
    logic [CW-1:0] credit = '0;
    logic          tok_valid = 1'b0;
    logic          tok_ready;
    logic          tok_ctrl = 1'b0;
    logic [7:0]    tok_data = '0;
    logic          fcc_req = 1'b0;
    logic          credit_use;
    logic          ds_d;
    logic          ds_s;

    always #4 clk = ~clk;

    ds_link_tx #(.DIV_N(NDIV), .CREDIT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .credit(credit),
        .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_ctrl(tok_ctrl),
        .tok_data(tok_data), .fcc_req(fcc_req), .credit_use(credit_use),
        .ds_d(ds_d), .ds_s(ds_s)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // Decoder state and counters
    logic       last_x = 0, pd = 0, ps = 0, prevp = 0, cpar = 0, cflag = 0, prev_esc = 0;
    bit         first_bit = 1;
    int         gap = 0, pst = 0, bitn = 0, need = 0;
    logic [7:0] acc = '0;
    logic [7:0] data_rx [0:511];
    int n_data = 0, n_null = 0, n_fcc = 0, n_eop = 0, n_eep = 0;
    int par_err = 0, ds_err = 0, per_err = 0, off_err = 0, pri_err = 0;
    int credit_cnt = 0, nocred_err = 0;
    int fcc_snap = 0;
    bit fcc_armed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Decode the line shortly after each rising edge.
    always begin
        @(posedge clk);
        #2;
        if (!rst_n || !link_en) begin
            if (ds_d || ds_s) off_err++;              // R10
            last_x = 0; pd = 0; ps = 0; prevp = 0; first_bit = 1;
            gap = 0; pst = 0; prev_esc = 0;
        end else begin
            gap++;
            if ((ds_d ^ ds_s) != last_x) begin
                if ((ds_d != pd) && (ds_s != ps)) ds_err++;   // R5
                if (!first_bit && gap != NDIV) per_err++;     // R6
                first_bit = 0;
                gap = 0;
                case (pst)
                    0: begin cpar = ds_d; pst = 1; end
                    1: begin cflag = ds_d; pst = 2; bitn = 0; acc = '0; need = ds_d ? 2 : 8; end
                    default: begin
                        if (cflag) acc = {acc[6:0], ds_d};
                        else acc[bitn] = ds_d;
                        bitn++;
                        if (bitn == need) begin
                            pst = 0;
                            if ((prevp ^ cpar ^ cflag) != 1'b1) par_err++;   // R3
                            prevp = ^acc;
                            if (!cflag) begin
                                if (n_data < 512) data_rx[n_data] = acc;
                                n_data++;
                                prev_esc = 0;
                            end else begin
                                case (acc[1:0])
                                    2'b11: prev_esc = 1;
                                    2'b00: begin
                                        if (prev_esc) n_null++;
                                        else begin
                                            n_fcc++;
                                            if (fcc_armed && (n_data - fcc_snap > 1)) pri_err++; // R9
                                            fcc_armed = 0;
                                        end
                                        prev_esc = 0;
                                    end
                                    2'b01: begin n_eop++; prev_esc = 0; end
                                    default: begin n_eep++; prev_esc = 0; end
                                endcase
                            end
                        end
                    end
                endcase
            end
            last_x = ds_d ^ ds_s;
            pd = ds_d;
            ps = ds_s;
        end
    end

    // Sample handshake outputs after the falling-edge input changes.
    always begin
        @(negedge clk);
        #2;
        if (credit_use) credit_cnt++;
        if (tok_valid && tok_ready && !tok_ctrl && credit == '0) nocred_err++;
    end

    task automatic send_tok(input logic c, input logic [7:0] v);
        @(negedge clk);
        tok_valid = 1'b1; tok_ctrl = c; tok_data = v;
        #1;
        while (!tok_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int base, mism;
        repeat (4) @(negedge clk);
        chk(!ds_d && !ds_s && !tok_ready, "R10 reset", {ds_d, ds_s, tok_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ds_d && !ds_s, "R10 disabled", {ds_d, ds_s}, 0);

        // Idle line: NULL fill only
        link_en = 1'b1;
        repeat (120) @(negedge clk);
        chk(n_null >= 5, "R4 null count", n_null, 5);
        chk(n_data == 0 && n_fcc == 0, "R4 nothing else", n_data + n_fcc, 0);

        // Every byte value, back to back
        credit = 4'd1;
        for (int i = 0; i < 256; i++) send_tok(1'b0, 8'(i));
        repeat (40) @(negedge clk);
        chk(n_data == 256, "R1 byte count", n_data, 256);
        mism = 0;
        for (int i = 0; i < 256; i++) if (data_rx[i] != 8'(i)) mism++;
        chk(mism == 0, "R1 byte values", mism, 0);
        chk(credit_cnt == 256, "R8 credit pulses", credit_cnt, 256);

        // Control tokens with no credit
        credit = '0;
        send_tok(1'b1, 8'h01);
        send_tok(1'b1, 8'h02);
        repeat (40) @(negedge clk);
        chk(n_eop == 1, "R2 normal end", n_eop, 1);
        chk(n_eep == 1, "R2 exceptional end", n_eep, 1);
        chk(credit_cnt == 256, "R8 no pulse for control", credit_cnt, 256);

        // Data held back while credit is zero
        base = n_data;
        @(negedge clk);
        tok_valid = 1'b1; tok_ctrl = 1'b0; tok_data = 8'h3C;
        repeat (200) @(negedge clk);
        chk(n_data == base, "R7 blocked data", n_data, base);
        credit = 4'd5;
        #1;
        while (!tok_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        tok_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(n_data == base + 1 && data_rx[base] == 8'h3C, "R7 released data", int'(data_rx[base]), 'h3C);
        chk(nocred_err == 0, "R7 ready without credit", nocred_err, 0);

        // Flow-control request on an idle line
        @(negedge clk); fcc_req = 1'b1;
        @(negedge clk); fcc_req = 1'b0;
        repeat (60) @(negedge clk);
        chk(n_fcc == 1, "R9 idle request", n_fcc, 1);

        // Requests that meet a busy byte stream
        fork
            begin
                for (int i = 0; i < 40; i++) send_tok(1'b0, 8'(i * 7));
            end
            begin
                repeat (3) begin
                    repeat (70) @(negedge clk);
                    fcc_snap = n_data; fcc_armed = 1;
                    fcc_req = 1'b1;
                    @(negedge clk); fcc_req = 1'b0;
                end
            end
        join
        repeat (60) @(negedge clk);
        chk(n_fcc == 4, "R9 one per request", n_fcc, 4);
        chk(pri_err == 0, "R9 ahead of waiting data", pri_err, 0);

        // Disable in the middle of a character, then restart
        send_tok(1'b0, 8'hF0);
        repeat (5) @(negedge clk);
        link_en = 1'b0;
        repeat (6) @(negedge clk);
        chk(!ds_d && !ds_s, "R10 quiet after disable", {ds_d, ds_s}, 0);
        base = n_null;
        link_en = 1'b1;
        repeat (100) @(negedge clk);
        chk(n_null > base, "R10 restart fill", n_null, base + 1);
        chk(par_err == 0, "R3 parity incl restart", par_err, 0);

        chk(ds_err == 0, "R5 one wire per bit", ds_err, 0);
        chk(per_err == 0, "R6 bit period", per_err, 0);
        chk(off_err == 0, "R10 wires low when off", off_err, 0);
        chk(credit_cnt == 298, "R8 total pulses", credit_cnt, 298);
        done = 1;
        finish_run();
    end

endmodule